// File: doc/BRIEF.md
# Banked Expansion RAM Window Controller

This block sits on the bus of an 8-bit 6502-class processor and turns a 16 KB CPU window into a view of one 16 KB slice of a 512 KB static RAM. Software picks the slice by writing a bank number into a write-only register. Any write inside the 64-byte register region at `$CFC0`–`$CFFF` loads it. Programs usually use `$CFFF`. A configuration input can also let the mirror range `$0FC0`–`$0FFF` load the register, because a board that cannot see the top address nibble cannot tell the two ranges apart.

The RAM address is the bank number placed above the 14-bit window offset. The controller drives the RAM chip-enable, output-enable and write-enable, and a data-bus drive enable for read data. The RAM is enabled only when the window strobe is active, at least one of the two slot-select lines is active, no refresh cycle is in progress, and the address is outside the register region. The register captures data on the falling edge of the bus clock phase. All logic runs on a fast system clock with a synchronous active-high reset, and the bus clock phase is sampled as an ordinary input.

Top module: `banked_ram_window`

## Requirements
- R1: When the sampled bus phase `cpu_phi2` goes from 1 to 0 with `cpu_rw`=0 and `cpu_addr` inside `$CFC0`–`$CFFF`, the bank register takes `cpu_data[4:0]` on that clock edge. `cpu_data[7:5]` are ignored. Addresses just outside the region (`$CFBF`, `$D000`) do not load it.
- R2: Writes to `$0FC0`–`$0FFF` load the bank register only when `cfg_alias_en`=1. When `cfg_alias_en`=0 they leave it unchanged.
- R3: Synchronous reset clears the bank register to 0, so `sram_addr[18:14]` is 0 after reset.
- R4: `sram_addr` always equals {bank[4:0], `cpu_addr[13:0]`}.
- R5: Writing 0 to `$CFFF` returns the window to bank 0 from any other bank.
- R6: `sram_ce_n` is 0 only when all of the following hold: `win_sel_n`=0, at least one of `slot2_sel_n`/`slot3_sel_n` is 0, `refresh_n`=1, and the address is outside the enabled register region(s).
- R7: `sram_we_n` is 0 only while the RAM is enabled, `cpu_rw`=0 and `cpu_phi2`=1.
- R8: `sram_oe_n`=0 and `data_drive_en`=1 exactly while the RAM is enabled and `cpu_rw`=1. Reads of the register region never drive the data bus.
- R9: A read (`cpu_rw`=1) of the register region, or a write with no falling phase edge, leaves the bank register unchanged.
- R10: Data written at the same window offset in different banks stays distinct and reads back per bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus as seen on writes |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_phi2 | input | 1 | Bus clock phase, high in the data phase |
| win_sel_n | input | 1 | Active-low 16 KB window strobe |
| slot2_sel_n | input | 1 | Active-low slot select, first |
| slot3_sel_n | input | 1 | Active-low slot select, second |
| refresh_n | input | 1 | Active-low refresh cycle indicator |
| cfg_alias_en | input | 1 | 1 = mirror range also loads the bank register |
| sram_addr | output | 19 | RAM address {bank, offset} |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| data_drive_en | output | 1 | Enables RAM read data onto the CPU bus |

## Verification
Bank writes are tried at both ends of the register region, just outside it, in the mirror range with the option off and then on, and with data whose top bits are set. These cases separate a full-region decode from a single-address decode, a decode that is too wide, and a load that lets unused data bits through. Window accesses are repeated with each gating input held inactive in turn (strobe, both slots high, refresh active) and with the strobe active on a register address, so that each term of the enable can be seen on its own. Data written at one offset in two banks and read back shows that the bank bits really reach the RAM address.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

    localparam int CPU_AW     = 16;
    localparam int CPU_DW     = 8;
    localparam int BANK_W     = 5;
    localparam int OFFS_W     = 14;
    localparam int REG_SPAN_W = 6;
    localparam int SRAM_AW    = BANK_W + OFFS_W;
    localparam int TAG_W      = CPU_AW - REG_SPAN_W;

    localparam logic [CPU_AW-1:0] REG_BASE   = 16'hCFC0;
    localparam logic [CPU_AW-1:0] ALIAS_BASE = 16'h0FC0;

    // Sampled CPU bus, active-high view
    typedef struct packed {
        logic [CPU_AW-1:0] addr;
        logic [CPU_DW-1:0] data;
        logic              rw;
        logic              phi2;
    } cpu_bus_t;

    // Select lines converted to active-high meaning
    typedef struct packed {
        logic window;
        logic slot_any;
        logic no_refresh;
    } sel_t;

    // Active-high RAM control bundle
    typedef struct packed {
        logic ce;
        logic oe;
        logic we;
        logic drive;
    } sram_ctl_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    function automatic logic in_region(input logic [CPU_AW-1:0] a,
                                       input logic [CPU_AW-1:0] base);
        return a[CPU_AW-1:REG_SPAN_W] == base[CPU_AW-1:REG_SPAN_W];
    endfunction

    function automatic logic reg_hit(input logic [CPU_AW-1:0] a,
                                     input logic alias_en);
        return in_region(a, REG_BASE) || (alias_en && in_region(a, ALIAS_BASE));
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [CPU_DW-1:0] b);
        return b[BANK_W-1:0];
    endfunction

    function automatic logic [SRAM_AW-1:0] join_addr(input logic [BANK_W-1:0] bank,
                                                     input logic [CPU_AW-1:0] a);
        return {bank, a[OFFS_W-1:0]};
    endfunction

endpackage

// File: rtl/phase_edge.sv
module phase_edge (
    input  logic clk,
    input  logic rst,
    input  logic phase_in,
    output logic phase_fall
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= phase_in;
    end

    assign phase_fall = phase_q && !phase_in;
endmodule

// File: rtl/bank_latch.sv
module bank_latch #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] bank
);
    always_ff @(posedge clk) begin
        if (rst)       bank <= '0;
        else if (load) bank <= din;
    end
endmodule

// File: rtl/window_ctrl.sv
module window_ctrl
    import banked_ram_pkg::*;
(
    input  sel_t      sel,
    input  cpu_bus_t  bus,
    input  logic      reg_access,
    output acc_kind_t kind,
    output sram_ctl_t ctl
);
    logic enabled;

    assign enabled = sel.window && sel.slot_any && sel.no_refresh && !reg_access;

    always_comb begin
        kind = ACC_IDLE;
        if (enabled) kind = bus.rw ? ACC_READ : ACC_WRITE;
    end

    always_comb begin
        ctl       = '0;
        ctl.ce    = enabled;
        unique case (kind)
            ACC_READ: begin
                ctl.oe    = 1'b1;
                ctl.drive = 1'b1;
            end
            ACC_WRITE: ctl.we = bus.phi2;
            default: ;
        endcase
    end
endmodule

// File: rtl/banked_ram_window.sv
module banked_ram_window
    import banked_ram_pkg::*;
#(
    parameter int AW = CPU_AW,
    parameter int DW = CPU_DW,
    parameter int BW = BANK_W,
    localparam int RAW = BW + OFFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_data,
    input  logic          cpu_rw,
    input  logic          cpu_phi2,
    input  logic          win_sel_n,
    input  logic          slot2_sel_n,
    input  logic          slot3_sel_n,
    input  logic          refresh_n,
    input  logic          cfg_alias_en,
    output logic [RAW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic          data_drive_en
);
    cpu_bus_t    bus;
    sel_t        sel;
    sram_ctl_t   ctl;
    acc_kind_t   kind;
    logic        phi2_fall;
    logic        hit;
    logic        load;
    logic [BW-1:0] bank;

    assign bus.addr = cpu_addr;
    assign bus.data = cpu_data;
    assign bus.rw   = cpu_rw;
    assign bus.phi2 = cpu_phi2;

    assign sel.window     = !win_sel_n;
    assign sel.slot_any   = !(slot2_sel_n && slot3_sel_n);
    assign sel.no_refresh = refresh_n;

    assign hit  = reg_hit(bus.addr, cfg_alias_en);
    assign load = phi2_fall && !bus.rw && hit;

    phase_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .phase_in  (bus.phi2),
        .phase_fall(phi2_fall)
    );

    bank_latch #(.W(BW)) u_bank (
        .clk (clk),
        .rst (rst),
        .load(load),
        .din (bank_of(bus.data)),
        .bank(bank)
    );

    window_ctrl u_win (
        .sel       (sel),
        .bus       (bus),
        .reg_access(hit),
        .kind      (kind),
        .ctl       (ctl)
    );

    assign sram_addr     = join_addr(bank, bus.addr);
    assign sram_ce_n     = !ctl.ce;
    assign sram_oe_n     = !ctl.oe;
    assign sram_we_n     = !ctl.we;
    assign data_drive_en = ctl.drive;
endmodule

// File: rtl/banked_ram_window_chk.sv
module banked_ram_window_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_rw,
    input logic        cpu_phi2,
    input logic        win_sel_n,
    input logic        slot2_sel_n,
    input logic        slot3_sel_n,
    input logic        refresh_n,
    input logic        cfg_alias_en,
    input logic [18:0] sram_addr,
    input logic        sram_ce_n,
    input logic        sram_oe_n,
    input logic        sram_we_n,
    input logic        data_drive_en
);
    logic ph_seen;
    logic rst_seen;
    logic in_regs;
    logic strobe;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst) ph_seen <= 1'b0;
        else     ph_seen <= cpu_phi2;
    end

    assign in_regs = (cpu_addr >= 16'hCFC0 && cpu_addr <= 16'hCFFF) ||
                     (cfg_alias_en && cpu_addr >= 16'h0FC0 && cpu_addr <= 16'h0FFF);
    assign strobe  = ph_seen && !cpu_phi2 && !cpu_rw && in_regs;

    always_ff @(posedge clk) begin
        if (rst_seen && !rst)
            AST_RESET_HOME: assert (sram_addr[18:14] == 5'd0); // R3
    end

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        strobe |=> sram_addr[18:14] == $past(cpu_data[4:0])); // R1

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(sram_addr[18:14])); // R9

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
        sram_addr[13:0] == cpu_addr[13:0]); // R4

    AST_CE_GATE: assert property (@(posedge clk) disable iff (rst)
        !sram_ce_n |-> (!win_sel_n && refresh_n && !(slot2_sel_n && slot3_sel_n) && !in_regs)); // R6

    AST_WE_PHASE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (cpu_phi2 && !cpu_rw && !sram_ce_n)); // R7

    AST_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
        data_drive_en |-> (!sram_oe_n && cpu_rw && !sram_ce_n)); // R8
endmodule

bind banked_ram_window banked_ram_window_chk u_chk (.*);

// File: tb/banked_ram_window_bench.sv
`timescale 1ns/1ps
module banked_ram_window_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1'b1;
    logic        cpu_phi2 = 1'b0;
    logic        win_sel_n = 1'b1;
    logic        slot2_sel_n = 1'b1;
    logic        slot3_sel_n = 1'b1;
    logic        refresh_n = 1'b1;
    logic        cfg_alias_en = 1'b0;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, data_drive_en;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    banked_ram_window u_banked_ram_window (.*);

    // Behavioural reference state
    int m_bank = 0;
    bit m_prev = 0;
    logic [7:0] ram   [int];
    logic [7:0] shadow[int];

    function automatic bit m_in_regs(input logic [15:0] a);
        return (a >= 16'hCFC0 && a <= 16'hCFFF) ||
               (cfg_alias_en && a >= 16'h0FC0 && a <= 16'h0FFF);
    endfunction

    function automatic bit m_enabled();
        return !win_sel_n && (!slot2_sel_n || !slot3_sel_n) && refresh_n
               && !m_in_regs(cpu_addr);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_bank = 0;
            m_prev = 0;
        end else begin
            if (m_prev && !cpu_phi2 && !cpu_rw && m_in_regs(cpu_addr))
                m_bank = cpu_data % 32;
            m_prev = cpu_phi2;
        end
        if (!sram_we_n && !sram_ce_n) ram[int'(sram_addr)] = cpu_data;
    end

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit en;
            en = m_enabled();
            check("R4 sram_addr", sram_addr, (m_bank * 16384) + (cpu_addr % 16384));
            check("R6 sram_ce_n", sram_ce_n, !en);
            check("R7 sram_we_n", sram_we_n, !(en && !cpu_rw && cpu_phi2));
            check("R8 sram_oe_n", sram_oe_n, !(en && cpu_rw));
            check("R8 data_drive_en", data_drive_en, en && cpu_rw);
        end
    end

    task automatic bus(input logic [15:0] a, input logic [7:0] d, input logic rw,
                       input logic win_n, input logic s2n = 1'b0, input logic s3n = 1'b1,
                       input logic refn = 1'b1);
        @(posedge clk); #1;
        cpu_addr = a; cpu_data = d; cpu_rw = rw; cpu_phi2 = 1'b0;
        win_sel_n = win_n; slot2_sel_n = s2n; slot3_sel_n = s3n; refresh_n = refn;
        repeat (2) @(posedge clk);
        #1 cpu_phi2 = 1'b1;
        repeat (2) @(posedge clk);
        #1 cpu_phi2 = 1'b0;
        @(posedge clk); #1;
        win_sel_n = 1'b1; cpu_rw = 1'b1;
    endtask

    task automatic check_bank(input string req, input int exp);
        @(negedge clk);
        check(req, sram_addr[18:14], exp);
    endtask

    task automatic win_write(input logic [13:0] off, input logic [7:0] d);
        bus({2'b01, off}, d, 1'b0, 1'b0);
        shadow[m_bank * 16384 + off] = d;
    endtask

    task automatic win_read(input logic [13:0] off, input string req);
        logic [7:0] got;
        int key;
        @(posedge clk); #1;
        cpu_addr = {2'b01, off}; cpu_rw = 1'b1; win_sel_n = 1'b0;
        slot2_sel_n = 1'b0; slot3_sel_n = 1'b1; refresh_n = 1'b1;
        repeat (2) @(posedge clk);
        #1 cpu_phi2 = 1'b1;
        @(negedge clk);
        key = int'(sram_addr);
        got = (!sram_oe_n && data_drive_en && ram.exists(key)) ? ram[key] : 8'h00;
        check(req, got, shadow.exists(m_bank * 16384 + off) ? shadow[m_bank * 16384 + off] : 8'h00);
        @(posedge clk); #1 cpu_phi2 = 1'b0;
        @(posedge clk); #1 win_sel_n = 1'b1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        check_bank("R3 reset bank", 0);

        win_write(14'h0123, 8'hA5);                 // bank 0
        bus(16'hCFFF, 8'hE3, 1'b0, 1'b1);           // R1 top bits ignored
        check_bank("R1 load via $CFFF, data[7:5] ignored", 3);
        win_write(14'h0123, 8'h5A);                 // bank 3

        bus(16'hCFC0, 8'h05, 1'b0, 1'b1);
        check_bank("R1 low end of region", 5);
        bus(16'hCFBF, 8'h0A, 1'b0, 1'b1);
        check_bank("R1 below region ignored", 5);
        bus(16'hD000, 8'h0B, 1'b0, 1'b1);
        check_bank("R1 above region ignored", 5);

        bus(16'h0FC5, 8'h07, 1'b0, 1'b1);
        check_bank("R2 alias ignored when off", 5);
        cfg_alias_en = 1'b1;
        bus(16'h0FF0, 8'h09, 1'b0, 1'b1);
        check_bank("R2 alias loads when on", 9);

        bus(16'hCFFF, 8'h1F, 1'b1, 1'b0);           // read with strobe active
        check_bank("R9 register read no load", 9);
        bus(16'h0FFF, 8'h02, 1'b1, 1'b1);
        check_bank("R9 alias read no load", 9);
        cfg_alias_en = 1'b0;

        bus({2'b01, 14'h0040}, 8'h11, 1'b0, 1'b0, 1'b1, 1'b1);      // R6 both slots high
        bus({2'b01, 14'h0041}, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0); // R6 refresh
        bus({2'b01, 14'h0042}, 8'h13, 1'b0, 1'b1);                  // R6 no strobe
        bus({2'b01, 14'h0043}, 8'h14, 1'b0, 1'b0, 1'b1, 1'b0);      // slot3 only
        shadow[m_bank * 16384 + 14'h0043] = 8'h14;

        bus(16'hCFFF, 8'h00, 1'b0, 1'b1);
        check_bank("R5 zero returns to home bank", 0);
        win_read(14'h0123, "R10 bank 0 readback");
        bus(16'hCFFF, 8'h03, 1'b0, 1'b1);
        win_read(14'h0123, "R10 bank 3 readback");
        bus(16'hCFFF, 8'h09, 1'b0, 1'b1);
        win_read(14'h0040, "R6 gated write left RAM untouched");
        win_read(14'h0043, "R6 second slot write stored");
        bus(16'hCFFF, 8'h00, 1'b0, 1'b1);
        check_bank("R5 zero again", 0);

        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule